// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Fetch Unit

This unit sits beside the execution core of a 16-bit processor with a 20-bit byte address space. It watches a maskable request line, gated by an interrupt-enable bit, and a non-maskable request input. For a maskable request it drives an active-low acknowledge output low twice. On the second pulse it captures the 8-bit type number that the interrupting device places on the low data bits. A non-maskable request skips the handshake and always uses type 2.

With the type known, the unit reads the four-byte table entry that starts at address `type * 4` through a byte-wide read port with a ready handshake. The two lower bytes form the 16-bit offset and the two upper bytes form the 16-bit segment, each little-endian. It then presents `segment * 16 + offset`, truncated to 20 bits, together with a one-cycle valid strobe.

The controller has six states. IDLE moves to FETCH when a non-maskable edge is pending, or to ACK_FIRST when the maskable request is high and enabled. ACK_FIRST moves to ACK_GAP when its pulse counter expires, ACK_GAP moves to ACK_SECOND, and ACK_SECOND moves to FETCH and captures the type. FETCH stays put while ready is low and advances one byte each time ready is high. After the fourth byte it moves to DONE, and DONE returns to IDLE after one cycle.

Top module: `irq_vector_unit`

## Requirements
- R1: During and immediately after reset, `ack_n` is high, `mem_rd` is low and `target_valid` is low.
- R2: A maskable request (`intr_req` high) is accepted only in IDLE and only while `int_enable` is 1. With `int_enable` at 0, no acknowledge pulse, memory read or valid strobe occurs.
- R3: A maskable acknowledge drives `ack_n` low exactly twice. Each low pulse lasts `ACK_CLKS` cycles, and the two pulses are separated by `GAP_CLKS` cycles (at least 1) of `ack_n` high.
- R4: The type number is captured from `ack_data` in the last cycle of the second pulse. Whatever is on `ack_data` during the first pulse has no effect on the vector used.
- R5: The unit reads the four bytes at addresses `type*4+0` through `type*4+3` in ascending order, one byte per cycle in which `mem_ready` is high. `mem_addr` holds steady and `mem_rd` stays high while `mem_ready` is low. Every address lies within the first 1024 bytes (bits 19:10 zero).
- R6: The offset is `{byte1, byte0}` and the segment is `{byte3, byte2}`. `target_addr` equals `(segment << 4) + offset` modulo 2^20, so a carry out of bit 19 is dropped.
- R7: `target_valid` is high for exactly one cycle, in the cycle after the fourth byte is accepted, and the unit is then idle again.
- R8: A rising edge on `nmi_req` is latched as pending and is served whatever the value of `int_enable`. It produces no acknowledge pulse and uses type 2, which means reading bytes 0x08 to 0x0B.
- R9: When a non-maskable edge and a maskable request are both present in IDLE, the non-maskable one is served first. A maskable request still held afterwards is served next, with its full handshake.
- R10: `nmi_req` held high produces only one service. A new service needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| intr_req | input | 1 | Maskable request level |
| int_enable | input | 1 | Maskable request enable |
| nmi_req | input | 1 | Non-maskable request, edge sensed |
| ack_n | output | 1 | Active-low acknowledge pulses |
| ack_data | input | 8 | Low data bits carrying the type number |
| mem_addr | output | 20 | Byte address of the table read |
| mem_rd | output | 1 | Read request, held until ready |
| mem_rdata | input | 8 | Read data, valid when ready is high |
| mem_ready | input | 1 | Read completion |
| target_addr | output | 20 | Computed service-routine address |
| target_valid | output | 1 | One-cycle strobe for target_addr |

## Verification
The assertions take three things for granted. `mem_ready` is meaningful only while `mem_rd` is high. The requester holds `ack_data` stable through the last clock of the second pulse. `intr_req` is dropped before the service completes whenever a single service is intended. The stimulus follows all three: the bench's memory model raises ready only in answer to a read, after zero to three wait cycles. Its acknowledge responder changes `ack_data` only at the falling edge of the clock on which a pulse is first seen low. Its request driver drops `intr_req` as soon as the first pulse appears, except in the priority test, where holding the request is the point of the test.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK_FIRST,
        ST_ACK_GAP,
        ST_ACK_SECOND,
        ST_FETCH,
        ST_DONE
    } irqv_state_e;

    localparam int TYPE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int MADDR_W  = 20;
    localparam int ENTRY_B  = 4;
    localparam logic [TYPE_W-1:0] NMI_TYPE = 8'd2;
endpackage

// File: rtl/irqv_nmi_latch.sv
module irqv_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic take,
    output logic nmi_hit
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise    = nmi_req & ~prev_q;
    assign nmi_hit = pend_q | rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi_req;
            pend_q <= (pend_q | rise) & ~take;
        end
    end
endmodule

// File: rtl/irqv_addr_calc.sv
module irqv_addr_calc
    import irqv_pkg::*;
(
    input  logic [TYPE_W-1:0]  vec_type,
    input  logic [1:0]         byte_idx,
    input  logic [7:0]         byte0,
    input  logic [7:0]         byte1,
    input  logic [7:0]         byte2,
    input  logic [7:0]         byte3,
    output logic [MADDR_W-1:0] rd_addr,
    output logic [MADDR_W-1:0] jump_addr
);
    localparam int PAD_W = MADDR_W - TYPE_W - 2;

    logic [WORD_W-1:0]  offset_w;
    logic [WORD_W-1:0]  segment_w;
    logic [MADDR_W-1:0] seg_shift;
    logic [MADDR_W-1:0] off_ext;

    assign rd_addr   = {{PAD_W{1'b0}}, vec_type, byte_idx};
    assign offset_w  = {byte1, byte0};
    assign segment_w = {byte3, byte2};
    assign seg_shift = {segment_w, 4'b0000};
    assign off_ext   = {{(MADDR_W-WORD_W){1'b0}}, offset_w};
    assign jump_addr = seg_shift + off_ext;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irqv_pkg::*;
#(
    parameter int ACK_CLKS = 2,
    parameter int GAP_CLKS = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               intr_req,
    input  logic               int_enable,
    input  logic               nmi_req,
    output logic               ack_n,
    input  logic [7:0]         ack_data,
    output logic [19:0]        mem_addr,
    output logic               mem_rd,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_ready,
    output logic [19:0]        target_addr,
    output logic               target_valid
);
    localparam int MAXC  = (ACK_CLKS > GAP_CLKS) ? ACK_CLKS : GAP_CLKS;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] ACK_LOAD = CNT_W'(ACK_CLKS - 1);
    localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CLKS - 1);

    irqv_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [1:0]         idx_q, idx_d;
    logic [TYPE_W-1:0]  type_q, type_d;
    logic [7:0]         vb_q [ENTRY_B];
    logic               store_en;
    logic               nmi_hit;
    logic               nmi_take;

    irqv_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_req (nmi_req),
        .take    (nmi_take),
        .nmi_hit (nmi_hit)
    );

    irqv_addr_calc u_calc (
        .vec_type  (type_q),
        .byte_idx  (idx_q),
        .byte0     (vb_q[0]),
        .byte1     (vb_q[1]),
        .byte2     (vb_q[2]),
        .byte3     (vb_q[3]),
        .rd_addr   (mem_addr),
        .jump_addr (target_addr)
    );

    // next-state and datapath steering
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        idx_d    = idx_q;
        type_d   = type_q;
        store_en = 1'b0;
        nmi_take = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (nmi_hit) begin
                    nmi_take = 1'b1;
                    type_d   = NMI_TYPE;
                    idx_d    = 2'd0;
                    state_d  = ST_FETCH;
                end else if (intr_req && int_enable) begin
                    cnt_d   = ACK_LOAD;
                    state_d = ST_ACK_FIRST;
                end
            end
            ST_ACK_FIRST: begin
                if (cnt_q == '0) begin
                    cnt_d   = GAP_LOAD;
                    state_d = ST_ACK_GAP;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ACK_GAP: begin
                if (cnt_q == '0) begin
                    cnt_d   = ACK_LOAD;
                    state_d = ST_ACK_SECOND;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ACK_SECOND: begin
                if (cnt_q == '0) begin
                    type_d  = ack_data;
                    idx_d   = 2'd0;
                    state_d = ST_FETCH;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_FETCH: begin
                if (mem_ready) begin
                    store_en = 1'b1;
                    if (idx_q == 2'd3) begin
                        state_d = ST_DONE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= 2'd0;
            type_q  <= '0;
            for (int i = 0; i < ENTRY_B; i++) vb_q[i] <= 8'h00;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            type_q  <= type_d;
            if (store_en) vb_q[idx_q] <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        ack_n        = 1'b1;
        mem_rd       = 1'b0;
        target_valid = 1'b0;
        unique case (state_q)
            ST_ACK_FIRST, ST_ACK_SECOND: ack_n = 1'b0;
            ST_FETCH:                    mem_rd = 1'b1;
            ST_DONE:                     target_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int ACK_CLKS = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ack_n,
    input logic        mem_rd,
    input logic        mem_ready,
    input logic [19:0] mem_addr,
    input logic        target_valid
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      low_cnt <= '0;
        else if (!ack_n) low_cnt <= low_cnt + 1'b1;
        else             low_cnt <= '0;
    end

    AST_ACK_READ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ack_n && mem_rd)); // R3
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n) |-> low_cnt == 16'(ACK_CLKS)); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr))); // R5
    AST_ADDR_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_addr[19:10] == 10'd0); // R5
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        target_valid |=> !target_valid); // R7
    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        target_valid |-> ($past(mem_rd) && $past(mem_ready))); // R7
endmodule

bind irq_vector_unit irqv_checker #(.ACK_CLKS(ACK_CLKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_n        (ack_n),
    .mem_rd       (mem_rd),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .target_valid (target_valid)
);

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;
    localparam int ACKC = 3;
    localparam int GAPC = 2;
    localparam int NV   = 6;
    // {nmi, type[7:0], seg[15:0], off[15:0], waits[1:0]}
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 8'h03, 16'h135F, 16'h0102, 2'd0},
        {1'b0, 8'hFF, 16'hFFFF, 16'hFFFF, 2'd2},
        {1'b0, 8'h00, 16'h0000, 16'h1234, 2'd1},
        {1'b1, 8'h02, 16'h2000, 16'h0010, 2'd3},
        {1'b0, 8'h80, 16'hABCD, 16'hEF01, 2'd1},
        {1'b1, 8'h02, 16'h0040, 16'h0000, 2'd0}
    };

    logic clk = 0, rst_n = 0;
    logic intr_req = 0, int_enable = 0, nmi_req = 0;
    logic ack_n, mem_rd, mem_ready, target_valid;
    logic [7:0] ack_data = 8'hEE, mem_rdata;
    logic [19:0] mem_addr, target_addr;
    logic [7:0] mem [1024];
    logic [1:0] wsel = 0, wcnt = 0;
    int n_chk = 0, n_bad = 0;
    int pulses = 0, low_run = 0, high_run = 0, bad_len = 0, bad_gap = 0;
    int rd_n = 0, rd_bad = 0, valids = 0;
    logic [7:0] cur_type = 0;
    logic prev_ack = 1;
    logic [19:0] rd_base = 0;

    always #2 clk = ~clk;

    irq_vector_unit #(.ACK_CLKS(ACKC), .GAP_CLKS(GAPC)) u0 (
        .clk(clk), .rst_n(rst_n), .intr_req(intr_req), .int_enable(int_enable),
        .nmi_req(nmi_req), .ack_n(ack_n), .ack_data(ack_data),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .target_addr(target_addr), .target_valid(target_valid));

    assign mem_rdata = mem[mem_addr[9:0]];
    assign mem_ready = mem_rd && (wcnt == wsel);
    always @(posedge clk) begin
        if (!mem_rd || mem_ready) wcnt <= 0;
        else                      wcnt <= wcnt + 1;
    end

    // monitor: pulses, responder, reads
    always @(negedge clk) begin
        if (!ack_n) begin
            low_run = low_run + 1;
            ack_data = (pulses >= 1) ? cur_type : 8'hEE;
            if (prev_ack && pulses == 1 && high_run < GAPC) bad_gap = bad_gap + 1;
        end else begin
            if (!prev_ack) begin
                if (low_run != ACKC) bad_len = bad_len + 1;
                pulses = pulses + 1;
                low_run = 0;
                high_run = 0;
            end
            high_run = high_run + 1;
        end
        prev_ack = ack_n;
        if (mem_rd && mem_ready) begin
            if (mem_addr != rd_base + 20'(rd_n % 4)) rd_bad = rd_bad + 1;
            rd_n = rd_n + 1;
        end
        if (target_valid) valids = valids + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_vec(input logic [7:0] t, input logic [15:0] seg, input logic [15:0] off);
        mem[{t, 2'b00}]     = off[7:0];
        mem[{t, 2'b01}]     = off[15:8];
        mem[{t, 2'b10}]     = seg[7:0];
        mem[{t, 2'b11}]     = seg[15:8];
    endtask

    task automatic clear_mon(input logic [7:0] t);
        @(posedge clk);
        pulses = 0; low_run = 0; high_run = 0; bad_len = 0; bad_gap = 0;
        rd_n = 0; rd_bad = 0; valids = 0;
        rd_base = {10'd0, t, 2'b00};
    endtask

    // wait for a valid strobe; returns captured address or flags timeout
    task automatic wait_valid(output logic [19:0] got, output bit ok);
        ok = 0; got = '0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!ack_n) intr_req = 0;
            if (target_valid) begin ok = 1; got = target_addr; break; end
        end
        @(negedge clk);
    endtask

    logic [19:0] got, exp;
    bit ok;

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        check("R1 ack_n", 32'(ack_n), 1);
        check("R1 mem_rd", 32'(mem_rd), 0);
        check("R1 valid", 32'(target_valid), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", {ack_n, mem_rd, target_valid}, 3'b100);

        for (int v = 0; v < NV; v++) begin
            logic nmi;
            logic [7:0] t;
            logic [15:0] seg, off;
            {nmi, t, seg, off, wsel} = VEC[v];
            set_vec(t, seg, off);
            cur_type = nmi ? 8'h55 : t;
            clear_mon(t);
            exp = {seg, 4'h0} + {4'h0, off};
            @(negedge clk);
            int_enable = nmi ? 1'b0 : 1'b1;
            if (nmi) begin
                nmi_req = 1; @(negedge clk); @(negedge clk); nmi_req = 0;
            end else intr_req = 1;
            wait_valid(got, ok);
            check("R6 target address", 32'(got), 32'(exp));
            check(nmi ? "R8 no pulses" : "R3 two pulses", pulses, nmi ? 0 : 2);
            check("R3 pulse length/gap", bad_len + bad_gap, 0);
            check("R5 read order", {rd_n, rd_bad}, {32'd4, 32'd0});
            check("R7 single strobe", valids, 1);
            if (!nmi) check("R4 type from second pulse", 32'(rd_base), 32'({t, 2'b00}));
        end

        // R2: masked request ignored
        clear_mon(8'h00);
        int_enable = 0; intr_req = 1;
        repeat (40) @(negedge clk);
        check("R2 masked pulses", pulses, 0);
        check("R2 masked reads", rd_n, 0);
        check("R2 masked valid", valids, 0);
        intr_req = 0;

        // R9: simultaneous nmi and intr, intr held
        set_vec(8'h02, 16'h0100, 16'h0005);
        set_vec(8'h21, 16'h0300, 16'h0007);
        cur_type = 8'h21; wsel = 0;
        clear_mon(8'h02);
        @(negedge clk);
        int_enable = 1; nmi_req = 1; intr_req = 1;
        for (int i = 0; i < 400 && !target_valid; i++) @(negedge clk);
        check("R9 nmi first", 32'(target_addr), 32'h01005);
        check("R9 nmi no pulse", pulses, 0);
        rd_base = {10'd0, 8'h21, 2'b00}; rd_n = 0; rd_bad = 0;
        @(negedge clk);
        wait_valid(got, ok);
        check("R9 maskable after", 32'(got), 32'h03007);
        check("R9 maskable pulses", pulses, 2);
        check("R5 second read order", {rd_n, rd_bad}, {32'd4, 32'd0});

        // R10: nmi still held high, no retrigger
        clear_mon(8'h02);
        repeat (60) @(negedge clk);
        check("R10 held nmi no retrigger", valids, 0);
        nmi_req = 0;
        @(negedge clk);
        nmi_req = 1; int_enable = 0;
        wait_valid(got, ok);
        check("R8 new edge with enable low", 32'(got), 32'h01005);
        nmi_req = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule